// File: doc/BRIEF.md
# Interval Timer with Compare Interrupt

This block is a per-processor interval timer. A free-running cycle counter starts at zero and advances by one on every clock. The counter is 32 or 64 bits wide, set by a parameter. One register address serves two registers. A read of that address returns the counter. A write to it loads a 32-bit compare value. The counter is never written and the compare register is never read back.

When the low 32 bits of the counter equal the compare value, a sticky pending flag is set. The interrupt request is the pending flag gated by a mask enable input. The flag is cleared by a clear strobe or by any new compare write. Software arms the next interrupt by writing a compare value ahead of the counter. A value that is already behind the counter stays silent until the low 32 bits wrap around to it. Each instance runs on its own and is not synchronised with any other.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter reads zero and then increases by exactly one per clock. `rd_data` shows the counter while `rd_en` is 1 and reads as zero while `rd_en` is 0.
- R2: The compare register resets to all ones. `pending` and `irq` are 0 out of reset and stay 0 while no compare write has been made.
- R3: When the low 32 bits of the counter equal the compare value in a cycle, `pending` is 1 from the following cycle onward.
- R4: `pending` stays 1 until a cycle with `pend_clr` = 1 or `wr_en` = 1 in which no match occurs. After such a cycle it reads 0.
- R5: A compare write clears `pending` unless the written value matches the counter in that same cycle.
- R6: `irq` equals `pending` AND `irq_en`. The mask enable never changes `pending`.
- R7: A compare write is used for the match in the same cycle it is presented. Writing the current counter value sets `pending` in the next cycle.
- R8: A compare value below the counter's current low 32 bits produces no `pending` while the counter moves away from it.
- R9: A match wins over `pend_clr` in the same cycle, so `pending` reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe for the timer address |
| rd_data | output | CNT_W | Counter value while `rd_en` is 1, else zero |
| wr_en | input | 1 | Write strobe for the timer address (loads compare) |
| wr_data | input | 32 | Compare value to load |
| irq_en | input | 1 | Interrupt mask enable (1 lets `pending` through) |
| pend_clr | input | 1 | Clears the pending flag |
| pending | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |

## Verification
Compare values are written at several distances ahead of the counter. These show whether the flag rises exactly one cycle after the equal cycle rather than earlier or later. A write equal to the live counter value separates use of the new compare value from use of the stale one. A value just behind the counter shows that "greater than or equal" is not being matched where "equal" is required. Clear strobes and writes are placed both apart from a match and on the match cycle, which shows priority and stickiness. The mask is toggled while the flag is set, to confirm that it gates only the output.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int CMP_W = 32;
    typedef logic [CMP_W-1:0] cmp_t;

    typedef struct packed {
        cmp_t cmp;
    } cmp_state_t;

    typedef struct packed {
        logic pend;
    } pend_state_t;
endpackage

// File: rtl/timer_counter.sv
module timer_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/timer_compare.sv
module timer_compare
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  cmp_t wr_data,
    input  cmp_t cnt_low,
    output logic match
);
    cmp_state_t st_d, st_q;
    cmp_t       cmp_eff;

    always_comb begin
        st_d     = st_q;
        cmp_eff  = wr_en ? wr_data : st_q.cmp;
        st_d.cmp = cmp_eff;
        match    = (cnt_low == cmp_eff);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cmp <= '1;
        else        st_q     <= st_d;
    end
endmodule

// File: rtl/timer_pending.sv
module timer_pending
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic pend_clr,
    input  logic wr_en,
    input  logic irq_en,
    output logic pending,
    output logic irq
);
    pend_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = match | (st_q.pend & ~pend_clr & ~wr_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;
    assign irq     = st_q.pend & irq_en;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    output logic [CNT_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             irq_en,
    input  logic             pend_clr,
    output logic             pending,
    output logic             irq
);
    logic [CNT_W-1:0] cnt;
    cmp_t             cnt_low;
    logic             match;

    timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    generate
        if (CNT_W == CMP_W) begin : g_narrow
            assign cnt_low = cnt;
        end else begin : g_wide
            assign cnt_low = cnt[CMP_W-1:0];
        end
    endgenerate

    timer_compare u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cnt_low (cnt_low),
        .match   (match)
    );

    timer_pending u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .pend_clr (pend_clr),
        .wr_en    (wr_en),
        .irq_en   (irq_en),
        .pending  (pending),
        .irq      (irq)
    );

    assign rd_data = rd_en ? cnt : '0;
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [CNT_W-1:0] rd_data,
    input logic             wr_en,
    input logic             pend_clr,
    input logic             irq_en,
    input logic             match,
    input logic             pending,
    input logic             irq
);
    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (!rd_en || rd_data == $past(rd_data) + 1'b1));

    // R2
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!pending && !irq));

    // R3
    match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> pending);

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !pend_clr && !wr_en) |=> pending);

    // R5
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !match) |=> !pending);

    // R6
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R6
    mask_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && pending) |-> irq);
endmodule

bind interval_timer timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .pend_clr (pend_clr),
    .irq_en   (irq_en),
    .match    (match),
    .pending  (pending),
    .irq      (irq)
);

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
    localparam int CNT_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_en = 1'b1;
    logic [CNT_W-1:0] rd_data;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic             irq_en = 1'b1;
    logic             pend_clr = 1'b0;
    logic             pending;
    logic             irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    interval_timer #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
        .pend_clr(pend_clr), .pending(pending), .irq(irq)
    );

    // Reference model built from the requirements; the queue carries the expected state
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } exp_t;
    exp_t             exp_q[$];
    logic [CNT_W-1:0] m_cnt = '0;
    logic [31:0]      m_cmp = '1;
    logic             m_pend = 1'b0;

    always @(posedge clk) begin
        logic [31:0] ce;
        logic        hit;
        exp_t        e;
        cycles++;
        if (!rst_n) begin
            m_cnt  = '0;
            m_cmp  = '1;
            m_pend = 1'b0;
        end else begin
            ce     = wr_en ? wr_data : m_cmp;
            hit    = (m_cnt[31:0] == ce);
            m_pend = hit | (m_pend & ~pend_clr & ~wr_en);
            m_cmp  = ce;
            m_cnt  = m_cnt + 1'b1;
        end
        e.cnt  = m_cnt;
        e.pend = m_pend;
        exp_q.push_back(e);
    end

    task automatic check(input string req, input logic [CNT_W-1:0] act,
                         input logic [CNT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle and compares at the falling edge
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0 && !done) begin
            e = exp_q.pop_front();
            check("R1 counter", rd_data, rd_en ? e.cnt : '0);
            check("R3 pending", {{(CNT_W-1){1'b0}}, pending}, {{(CNT_W-1){1'b0}}, e.pend});
            check("R6 irq", {{(CNT_W-1){1'b0}}, irq}, {{(CNT_W-1){1'b0}}, e.pend & irq_en});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cmp(input logic [31:0] v);
        wr_data = v;
        wr_en   = 1'b1;
        step(1);
        wr_en   = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        while (cycles < 20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
        finish_run();
    end

    initial begin
        logic [31:0] c;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 / R2: state right after reset
        check("R1 reset count", rd_data, 1);
        check("R2 reset pending", {63'b0, pending}, 64'd0);
        check("R2 reset irq", {63'b0, irq}, 64'd0);
        step(30);
        check("R2 quiet", {63'b0, pending}, 64'd0);

        // R3: compare ahead of counter
        c = rd_data[31:0];
        write_cmp(c + 32'd10);
        while (rd_data[31:0] != c + 32'd10) step(1);
        check("R3 before match", {63'b0, pending}, 64'd0);
        step(1);
        check("R3 after match", {63'b0, pending}, 64'd1);

        // R4: sticky then cleared
        step(5);
        check("R4 sticky", {63'b0, pending}, 64'd1);
        pend_clr = 1'b1; step(1); pend_clr = 1'b0;
        check("R4 clear", {63'b0, pending}, 64'd0);

        // R6: mask gates only the output
        irq_en = 1'b0;
        c = rd_data[31:0];
        write_cmp(c + 32'd4);
        step(5);
        check("R6 pend masked", {63'b0, pending}, 64'd1);
        check("R6 irq masked", {63'b0, irq}, 64'd0);
        irq_en = 1'b1;
        #1 check("R6 irq unmasked", {63'b0, irq}, 64'd1);

        // R5: write of a far value clears the flag
        c = rd_data[31:0];
        write_cmp(c + 32'd1000);
        check("R5 write clears", {63'b0, pending}, 64'd0);

        // R7: write equal to the live counter
        c = rd_data[31:0];
        write_cmp(c);
        check("R7 same cycle", {63'b0, pending}, 64'd1);

        // R8: compare just behind the counter
        c = rd_data[31:0];
        write_cmp(c - 32'd3);
        step(60);
        check("R8 behind", {63'b0, pending}, 64'd0);

        // R9: clear on the match cycle
        c = rd_data[31:0];
        write_cmp(c + 32'd6);
        while (rd_data[31:0] != c + 32'd6) step(1);
        pend_clr = 1'b1; step(1); pend_clr = 1'b0;
        check("R9 match over clear", {63'b0, pending}, 64'd1);

        // R1: read disabled
        rd_en = 1'b0;
        #1 check("R1 read off", rd_data, '0);
        step(2);
        rd_en = 1'b1;
        step(2);
        finish_run();
    end
endmodule